// File: doc/BRIEF.md
# Root Port Bridge Control Register

This block holds the 16-bit bridge control word of a root port's configuration space, word offset 3Eh, and the one implemented status flag of the secondary status word at offset 1Eh (bit 8, detected parity error). Software reaches both through a configuration port that writes per byte lane and reads combinationally.

The control bits act directly on side-band behaviour. One bit asks for a hot reset of the downstream link. One bit decides whether error messages arriving from downstream are passed upstream. One bit decides whether poisoned traffic from downstream raises the parity-error flag. The legacy timer, fast back-to-back and master-abort positions are hardwired to zero. The VGA, VGA 16-bit decode and ISA control bits are stored so software can read them back. Other decode logic uses them.

Top module: `bctl_top`

## Requirements
- R1: After reset the control word and the secondary status word both read 0000h, `hotResetReq` is 0 and `errFwdValid` is 0.
- R2: Control bits 15:7 and bit 5 always read as zero. Writing ones to them has no effect.
- R3: Control bits 6, 4, 3, 2, 1 and 0 read back what was last written to them. Write enable bit 0 gates data bits 7:0 and write enable bit 1 gates data bits 15:8. A lane whose enable is 0 is left unchanged.
- R4: `hotResetReq` follows control bit 6 with one cycle of lag. It rises on the cycle after the write that sets the bit, and it falls on the cycle after the write that clears it.
- R5: When control bit 1 is 1 and an error message is accepted, `errFwdValid` pulses for one cycle on the next cycle with the same class on `errFwdClass`. The classes are 0 = correctable, 1 = non-fatal and 2 = fatal. Class 3 is never forwarded. When control bit 1 is 0, no message is forwarded. The bit value in force at the clock edge that accepts the message is the one that decides.
- R6: When control bit 0 is 1 and a received packet is marked poisoned, status bit 8 is set on that edge if the packet kind is 1 (memory write) or 2 (completion). Kinds 0 and 3 never set it. When control bit 0 is 0, no packet sets it.
- R7: Status bit 8 is write-1-to-clear. It is cleared only by a write to 1Eh with write enable bit 1 and data bit 8 both 1. All other status bits read zero.
- R8: If a set event and a clear of status bit 8 fall on the same edge, the bit ends up set.
- R9: Reads from any offset other than 3Eh and 1Eh return zero. Writes to those offsets change neither register. Address bit 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte address (bit 0 ignored) |
| cfgByteEn | input | 2 | Per-lane write enables |
| cfgWrData | input | 16 | Configuration write data |
| cfgRdData | output | 16 | Combinational read data for `cfgAddr` |
| rxValid | input | 1 | A downstream packet is seen this cycle |
| rxKind | input | 2 | Packet kind: 0 other, 1 memory write, 2 completion, 3 other |
| rxPoison | input | 1 | Packet is marked poisoned |
| errMsgValid | input | 1 | Error message received from downstream |
| errMsgClass | input | 2 | Error message class |
| hotResetReq | output | 1 | Hot-reset request toward the downstream link |
| errFwdValid | output | 1 | One-cycle pulse: error message passed upstream |
| errFwdClass | output | 2 | Class of the forwarded message |

## Verification
Two pairs of functions can land on the same clock edge. In the first pair, a poisoned packet that sets status bit 8 meets a write-1-to-clear of that bit. The bench drives both in one cycle and expects the bit to read 1 afterwards. In the second pair, an error message arrives in the same cycle as a write that turns forwarding off. The bench expects the message to pass, because the enable value in force at that edge decides. A scoreboard queue holds the expected forwards, and a monitor matches each pulse against it.

// File: rtl/bctl_pkg.sv
package bctl_pkg;
  localparam int REG_W   = 16;
  localparam int LANE_W  = 8;
  localparam int LANES   = REG_W / LANE_W;
  localparam logic [REG_W-1:0] CTRL_RW_MASK = 16'h005F;
  localparam int HOTRST_BIT = 6;
  localparam int SERR_BIT   = 1;
  localparam int PERE_BIT   = 0;
  localparam int DPD_BIT    = 8;
  localparam int DPD_LANE   = DPD_BIT / LANE_W;

  typedef enum logic [1:0] {
    KIND_OTHER = 2'd0,
    KIND_MWR   = 2'd1,
    KIND_CPL   = 2'd2,
    KIND_RSVD  = 2'd3
  } rxKind_e;

  typedef struct packed {
    logic [LANES-1:0] ctrlWr;
    logic             statClr;
    logic             statSet;
    logic             errPass;
    logic             rdCtrl;
    logic             rdStat;
  } bctlStrb_t;
endpackage

// File: rtl/bctl_ctrl.sv
module bctl_ctrl
  import bctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h3E,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h1E
) (
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [LANES-1:0]  cfgByteEn,
  input  logic [REG_W-1:0]  cfgWrData,
  input  logic              rxValid,
  input  logic [1:0]        rxKind,
  input  logic              rxPoison,
  input  logic              errMsgValid,
  input  logic [1:0]        errMsgClass,
  input  logic              serrEn,
  input  logic              pereEn,
  output bctlStrb_t         strb
);
  logic hitCtrl, hitStat, kindOk;

  assign hitCtrl = (cfgAddr[ADDR_W-1:1] == CTRL_OFS[ADDR_W-1:1]);
  assign hitStat = (cfgAddr[ADDR_W-1:1] == STAT_OFS[ADDR_W-1:1]);
  assign kindOk  = (rxKind == KIND_MWR) || (rxKind == KIND_CPL);

  always_comb begin
    strb.ctrlWr  = (cfgWe && hitCtrl) ? cfgByteEn : '0;
    strb.statClr = cfgWe && hitStat && cfgByteEn[DPD_LANE] && cfgWrData[DPD_BIT];
    strb.statSet = rxValid && rxPoison && kindOk && pereEn;
    strb.errPass = errMsgValid && serrEn && (errMsgClass != 2'b11);
    strb.rdCtrl  = hitCtrl;
    strb.rdStat  = hitStat;
  end
endmodule

// File: rtl/bctl_dp.sv
module bctl_dp
  import bctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  bctlStrb_t        strb,
  input  logic [REG_W-1:0] cfgWrData,
  input  logic [1:0]       errMsgClass,
  output logic [REG_W-1:0] cfgRdData,
  output logic             serrEn,
  output logic             pereEn,
  output logic             hotResetReq,
  output logic             errFwdValid,
  output logic [1:0]       errFwdClass
);
  logic [REG_W-1:0] ctrlReg;
  logic             dpdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else begin
      for (int b = 0; b < LANES; b++) begin
        if (strb.ctrlWr[b])
          ctrlReg[b*LANE_W +: LANE_W] <= cfgWrData[b*LANE_W +: LANE_W] &
                                         CTRL_RW_MASK[b*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dpdReg <= 1'b0;
    else if (strb.statSet)  dpdReg <= 1'b1;
    else if (strb.statClr)  dpdReg <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hotResetReq <= 1'b0;
      errFwdValid <= 1'b0;
      errFwdClass <= '0;
    end else begin
      hotResetReq <= ctrlReg[HOTRST_BIT];
      errFwdValid <= strb.errPass;
      if (strb.errPass) errFwdClass <= errMsgClass;
    end
  end

  assign serrEn = ctrlReg[SERR_BIT];
  assign pereEn = ctrlReg[PERE_BIT];

  always_comb begin
    cfgRdData = '0;
    if (strb.rdCtrl)      cfgRdData = ctrlReg;
    else if (strb.rdStat) cfgRdData[DPD_BIT] = dpdReg;
  end

  AST_HOTRST_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hotResetReq) |-> $past(ctrlReg[HOTRST_BIT])); // R4
  AST_FWD_NEEDS_SERR: assert property (@(posedge clk) disable iff (!rstN)
    errFwdValid |-> $past(ctrlReg[SERR_BIT])); // R5
  AST_FWD_NO_RSVD: assert property (@(posedge clk) disable iff (!rstN)
    errFwdValid |-> (errFwdClass != 2'b11)); // R5
  AST_DPD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dpdReg) && !$past(strb.statClr)) |-> dpdReg); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.statSet) |-> dpdReg); // R8
endmodule

// File: rtl/bctl_top.sv
module bctl_top
  import bctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h3E,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h1E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [1:0]        cfgByteEn,
  input  logic [15:0]       cfgWrData,
  output logic [15:0]       cfgRdData,
  input  logic              rxValid,
  input  logic [1:0]        rxKind,
  input  logic              rxPoison,
  input  logic              errMsgValid,
  input  logic [1:0]        errMsgClass,
  output logic              hotResetReq,
  output logic              errFwdValid,
  output logic [1:0]        errFwdClass
);
  bctlStrb_t strb;
  logic serrEn, pereEn;

  bctl_ctrl #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)) u_ctrl (
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData),
    .rxValid(rxValid), .rxKind(rxKind), .rxPoison(rxPoison),
    .errMsgValid(errMsgValid), .errMsgClass(errMsgClass),
    .serrEn(serrEn), .pereEn(pereEn), .strb(strb)
  );

  bctl_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWrData(cfgWrData),
    .errMsgClass(errMsgClass), .cfgRdData(cfgRdData),
    .serrEn(serrEn), .pereEn(pereEn), .hotResetReq(hotResetReq),
    .errFwdValid(errFwdValid), .errFwdClass(errFwdClass)
  );
endmodule

// File: tb/bctl_top_bench.sv
module bctl_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [7:0] cfgAddr = 8'h00;
  logic [1:0] cfgByteEn = 2'b00;
  logic [15:0] cfgWrData = 16'h0000;
  logic [15:0] cfgRdData;
  logic rxValid = 1'b0;
  logic [1:0] rxKind = 2'd0;
  logic rxPoison = 1'b0;
  logic errMsgValid = 1'b0;
  logic [1:0] errMsgClass = 2'd0;
  logic hotResetReq, errFwdValid;
  logic [1:0] errFwdClass;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [1:0] sbQ[$];

  always #10 clk = ~clk;

  bctl_top u_bctl_top (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [7:0] a, logic [1:0] be, logic [15:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgByteEn = be; cfgWrData = d;
    @(negedge clk);
    cfgWe = 1'b0; cfgByteEn = 2'b00;
  endtask

  task automatic cfgRead(string req, logic [7:0] a, logic [15:0] exp);
    cfgAddr = a;
    #1;
    chk(req, cfgRdData, exp);
  endtask

  task automatic sendPkt(logic [1:0] k, logic p);
    rxValid = 1'b1; rxKind = k; rxPoison = p;
    @(negedge clk);
    rxValid = 1'b0; rxPoison = 1'b0;
  endtask

  task automatic sendErr(logic [1:0] c, bit serrModel);
    errMsgValid = 1'b1; errMsgClass = c;
    if (serrModel && c != 2'b11) sbQ.push_back(c);
    @(negedge clk);
    errMsgValid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rstN && errFwdValid) begin
      if (sbQ.size() == 0) begin
        chk("R5 unexpected forward", {14'd0, errFwdClass}, 16'hFFFF);
      end else begin
        logic [1:0] e;
        e = sbQ.pop_front();
        chk("R5 forward class", {14'd0, errFwdClass}, {14'd0, e});
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    cfgRead("R1 ctrl reset", 8'h3E, 16'h0000);
    cfgRead("R1 status reset", 8'h1E, 16'h0000);
    chk("R1 hotResetReq reset", {15'd0, hotResetReq}, 16'h0);
    chk("R1 errFwdValid reset", {15'd0, errFwdValid}, 16'h0);

    // R2/R3: ones everywhere, only RW bits stick; bit 6 excluded for now
    cfgWrite(8'h3E, 2'b11, 16'hFFBF);
    cfgRead("R2 R3 ctrl all ones", 8'h3E, 16'h001F);
    cfgWrite(8'h3E, 2'b10, 16'h0000);
    cfgRead("R3 lane 1 only leaves low byte", 8'h3E, 16'h001F);
    cfgWrite(8'h3F, 2'b01, 16'h0014);
    cfgRead("R3 R9 odd address low lane", 8'h3E, 16'h0014);

    // R9 other offsets
    cfgWrite(8'h40, 2'b11, 16'hFFFF);
    cfgRead("R9 ctrl unchanged", 8'h3E, 16'h0014);
    cfgRead("R9 other offset reads zero", 8'h40, 16'h0000);

    // R4 hot reset latency
    cfgWrite(8'h3E, 2'b01, 16'h0040);
    chk("R4 no rise same cycle", {15'd0, hotResetReq}, 16'h0);
    @(negedge clk);
    chk("R4 rise one cycle later", {15'd0, hotResetReq}, 16'h1);
    cfgRead("R4 bit 6 readback", 8'h3E, 16'h0040);
    cfgWrite(8'h3E, 2'b01, 16'h0000);
    chk("R4 still high same cycle", {15'd0, hotResetReq}, 16'h1);
    @(negedge clk);
    chk("R4 fall one cycle later", {15'd0, hotResetReq}, 16'h0);

    // R5 forwarding disabled
    sendErr(2'd0, 0); sendErr(2'd2, 0);
    @(negedge clk);
    chk("R5 dropped when disabled", {15'd0, errFwdValid}, 16'h0);
    // R5 enabled, all classes
    cfgWrite(8'h3E, 2'b01, 16'h0002);
    sendErr(2'd0, 1); sendErr(2'd1, 1); sendErr(2'd3, 1); sendErr(2'd2, 1);
    @(negedge clk);
    chk("R5 single cycle pulse", {15'd0, errFwdValid}, 16'h0);
    // R5 same-edge disable: old enable decides
    errMsgValid = 1'b1; errMsgClass = 2'd1; sbQ.push_back(2'd1);
    cfgWrite(8'h3E, 2'b01, 16'h0000);
    errMsgValid = 1'b0;
    @(negedge clk);
    chk("R5 queue drained", sbQ.size(), 16'h0);

    // R6 poison with enable off
    sendPkt(2'd1, 1); sendPkt(2'd2, 1);
    cfgRead("R6 no set when disabled", 8'h1E, 16'h0000);
    cfgWrite(8'h3E, 2'b01, 16'h0001);
    sendPkt(2'd0, 1); sendPkt(2'd3, 1); sendPkt(2'd1, 0);
    cfgRead("R6 other kinds and clean no set", 8'h1E, 16'h0000);
    sendPkt(2'd1, 1);
    cfgRead("R6 poisoned write sets", 8'h1E, 16'h0100);

    // R7 clear rules
    cfgWrite(8'h1E, 2'b11, 16'hFEFF);
    cfgRead("R7 write zero keeps", 8'h1E, 16'h0100);
    cfgWrite(8'h1E, 2'b01, 16'hFFFF);
    cfgRead("R7 lane 0 only keeps", 8'h1E, 16'h0100);
    cfgWrite(8'h1E, 2'b10, 16'h0100);
    cfgRead("R7 W1C clears", 8'h1E, 16'h0000);
    sendPkt(2'd2, 1);
    cfgRead("R6 poisoned completion sets", 8'h1E, 16'h0100);

    // R8 set and clear on the same edge
    cfgWrite(8'h1E, 2'b10, 16'h0100);
    cfgRead("R8 cleared before race", 8'h1E, 16'h0000);
    rxValid = 1'b1; rxKind = 2'd1; rxPoison = 1'b1;
    cfgWrite(8'h1E, 2'b10, 16'h0100);
    rxValid = 1'b0; rxPoison = 1'b0;
    cfgRead("R8 set wins", 8'h1E, 16'h0100);

    // R2 again: ones to RO high byte leave zero
    cfgWrite(8'h3E, 2'b11, 16'hFF20);
    cfgRead("R2 RO bits stay zero", 8'h3E, 16'h0000);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule